// File: doc/BRIEF.md
# Rotating Register Base Renamer

This block turns a virtual register index into a physical register index for three register files: general, floating-point and predicate. Each file keeps its own rotating base. Inside a file's rotating region, the physical index is the virtual index moved forward by that base. The result wraps around the end of the region. Indices outside the region come out unchanged.

A loop-branch unit rotates the registers by pulsing a step strobe. The step moves all three bases down by one in the same cycle. A clear strobe sets all three bases back to zero. The size of the general-file region is set in units of eight registers. The floating-point and predicate regions are fixed. The mapping path is combinational, so the physical index follows the virtual index and the file select in the same cycle. Only the bases are registered.

Top module: `rrb_renamer`

## Requirements
- R1: After reset all three bases are zero, so every index in every region maps to itself.
- R2: Static indices pass through unchanged: general and floating-point indices below 32, and predicate indices below 16.
- R3: Inside a rotating region that starts at S and has size N, with base B, virtual index v maps to S + ((v - S) + B) mod N. The floating-point region covers 32..127 (N = 96). The predicate region covers 16..63 (N = 48).
- R4: A cycle with rotateStep high and rotateClear low decrements every base by one modulo its own region size, so 0 becomes N-1. The new base is visible from the next cycle. For example, after one step, floating-point index 32 maps to 127 and predicate index 16 maps to 63.
- R5: rotateClear sets all three bases to zero on the next cycle. It takes priority over rotateStep in the same cycle.
- R6: The general region starts at 32 and holds 8 × sorUnits registers. Values of sorUnits above 12 are treated as 12. General indices at or above 32 + 8 × sorUnits pass through unchanged. sorUnits may only change while the general base is zero.
- R7: With sorUnits = 0 the general file does not rotate. A step leaves the general base at zero.
- R8: In a cycle with neither strobe high, every base holds its value.
- R9: fileSel selects the file: 0 is general, 1 is floating-point, 2 is predicate. The value 3 selects no file, and physIdx then equals virtIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fileSel | input | 2 | File select: 0 general, 1 floating-point, 2 predicate, 3 none |
| virtIdx | input | 7 | Virtual register index |
| sorUnits | input | 4 | General rotating-region size in units of 8 registers |
| rotateStep | input | 1 | Decrement all bases by one |
| rotateClear | input | 1 | Reset all bases to zero |
| physIdx | output | 7 | Physical register index (combinational) |

## Verification
On every cycle, the assertions check the following:
- The floating-point and predicate bases stay inside their regions.
- A clear zeroes all bases.
- An idle cycle holds them.
- A predicate step wraps from 0 to 47.
- Static and unselected indices pass through.

Only the bench sweeps show the rest: the full wrap-around arithmetic over every index and file after many steps, the clamp on the general region size, the static behaviour with a zero-size general region, and the pass-through of general indices above the region.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int NUM_FILES = 3;

  typedef enum logic [1:0] {
    FILE_GR   = 2'd0,
    FILE_FR   = 2'd1,
    FILE_PR   = 2'd2,
    FILE_NONE = 2'd3
  } regFile_e;

  typedef struct packed {
    logic clearAll;
    logic stepDown;
  } rrbCtrl_t;
endpackage

// File: rtl/rrb_ctrl.sv
module rrb_ctrl
  import rrb_pkg::*;
(
  input  logic     rotateStep,
  input  logic     rotateClear,
  output rrbCtrl_t ctrl
);
  // Clear wins over a simultaneous step.
  always_comb begin
    ctrl.clearAll = rotateClear;
    ctrl.stepDown = rotateStep & ~rotateClear;
  end
endmodule

// File: rtl/rrb_datapath.sv
module rrb_datapath
  import rrb_pkg::*;
#(
  parameter int GR_REGS     = 128,
  parameter int FR_REGS     = 128,
  parameter int PR_REGS     = 64,
  parameter int GR_ROT_BASE = 32,
  parameter int FR_ROT_BASE = 32,
  parameter int PR_ROT_BASE = 16,
  parameter int IDX_W       = 7,
  parameter int SOR_W       = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rrbCtrl_t                          ctrl,
  input  logic [1:0]                        fileSel,
  input  logic [IDX_W-1:0]                  virtIdx,
  input  logic [SOR_W-1:0]                  sorUnits,
  output logic [IDX_W-1:0]                  physIdx,
  output logic [NUM_FILES-1:0][IDX_W-1:0]   baseVec
);
  localparam int SZ_W       = IDX_W + 1;
  localparam int SUM_W      = SZ_W + 1;
  localparam int GR_MAX_SOR = (GR_REGS - GR_ROT_BASE) / 8;

  logic [SOR_W-1:0] sorClamp;
  logic [SZ_W-1:0]  grSize;

  assign sorClamp = (int'(sorUnits) > GR_MAX_SOR) ? SOR_W'(GR_MAX_SOR) : sorUnits;
  assign grSize   = SZ_W'(sorClamp) << 3;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    localparam int START = (f == 0) ? GR_ROT_BASE : (f == 1) ? FR_ROT_BASE : PR_ROT_BASE;
    localparam int LIMIT = (f == 0) ? GR_REGS : (f == 1) ? FR_REGS : PR_REGS;

    logic [SZ_W-1:0]  regionSize;
    logic [IDX_W-1:0] baseQ;
    logic [IDX_W-1:0] mappedF;
    logic [SZ_W-1:0]  relIdx;
    logic [SUM_W-1:0] sumIdx;

    if (f == 0) begin : g_prog
      assign regionSize = grSize;
    end else begin : g_fixed
      assign regionSize = SZ_W'(LIMIT - START);
    end

    // Base register: decrement modulo region size, clear has priority.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
      end else if (ctrl.clearAll) begin
        baseQ <= '0;
      end else if (ctrl.stepDown) begin
        if (regionSize == '0) begin
          baseQ <= '0;
        end else if (baseQ == '0 || SZ_W'(baseQ) >= regionSize) begin
          baseQ <= IDX_W'(regionSize - 1'b1);
        end else begin
          baseQ <= baseQ - 1'b1;
        end
      end
    end

    // Rename: offset inside region, wrap once, rebase.
    always_comb begin
      mappedF = virtIdx;
      relIdx  = '0;
      sumIdx  = '0;
      if (SZ_W'(virtIdx) >= SZ_W'(START)) begin
        relIdx = SZ_W'(virtIdx) - SZ_W'(START);
        if (relIdx < regionSize) begin
          sumIdx = SUM_W'(relIdx) + SUM_W'(baseQ);
          if (sumIdx >= SUM_W'(regionSize)) begin
            sumIdx = sumIdx - SUM_W'(regionSize);
          end
          mappedF = IDX_W'(sumIdx + SUM_W'(START));
        end
      end
    end

    assign baseVec[f] = baseQ;
  end

  always_comb begin
    case (regFile_e'(fileSel))
      FILE_GR: physIdx = g_file[0].mappedF;
      FILE_FR: physIdx = g_file[1].mappedF;
      FILE_PR: physIdx = g_file[2].mappedF;
      default: physIdx = virtIdx;
    endcase
  end
endmodule

// File: rtl/rrb_renamer.sv
module rrb_renamer
  import rrb_pkg::*;
#(
  parameter int GR_REGS     = 128,
  parameter int FR_REGS     = 128,
  parameter int PR_REGS     = 64,
  parameter int GR_ROT_BASE = 32,
  parameter int FR_ROT_BASE = 32,
  parameter int PR_ROT_BASE = 16,
  parameter int IDX_W       = 7,
  parameter int SOR_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       fileSel,
  input  logic [IDX_W-1:0] virtIdx,
  input  logic [SOR_W-1:0] sorUnits,
  input  logic             rotateStep,
  input  logic             rotateClear,
  output logic [IDX_W-1:0] physIdx
);
  rrbCtrl_t                            ctrl;
  logic [NUM_FILES-1:0][IDX_W-1:0]     baseVec;

  rrb_ctrl u_ctrl (
    .rotateStep (rotateStep),
    .rotateClear(rotateClear),
    .ctrl       (ctrl)
  );

  rrb_datapath #(
    .GR_REGS    (GR_REGS),
    .FR_REGS    (FR_REGS),
    .PR_REGS    (PR_REGS),
    .GR_ROT_BASE(GR_ROT_BASE),
    .FR_ROT_BASE(FR_ROT_BASE),
    .PR_ROT_BASE(PR_ROT_BASE),
    .IDX_W      (IDX_W),
    .SOR_W      (SOR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .fileSel (fileSel),
    .virtIdx (virtIdx),
    .sorUnits(sorUnits),
    .physIdx (physIdx),
    .baseVec (baseVec)
  );
endmodule

// File: rtl/rrb_renamer_chk.sv
module rrb_renamer_chk #(
  parameter int FR_REGS     = 128,
  parameter int PR_REGS     = 64,
  parameter int FR_ROT_BASE = 32,
  parameter int PR_ROT_BASE = 16,
  parameter int IDX_W       = 7,
  parameter int NFILES      = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [1:0]                    fileSel,
  input logic [IDX_W-1:0]              virtIdx,
  input logic                          rotateStep,
  input logic                          rotateClear,
  input logic [IDX_W-1:0]              physIdx,
  input logic [NFILES-1:0][IDX_W-1:0]  baseVec
);
  localparam int FR_SIZE = FR_REGS - FR_ROT_BASE;
  localparam int PR_SIZE = PR_REGS - PR_ROT_BASE;

  AST_FR_BASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(baseVec[1]) < FR_SIZE); // R4
  AST_PR_BASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(baseVec[2]) < PR_SIZE); // R4
  AST_PR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (rotateStep && !rotateClear) |=>
      (int'(baseVec[2]) == (($past(baseVec[2]) == '0) ? PR_SIZE - 1 : int'($past(baseVec[2])) - 1))); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    rotateClear |=> (baseVec == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rotateStep && !rotateClear) |=> $stable(baseVec)); // R8
  AST_STATIC_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (fileSel == 2'd2 && int'(virtIdx) < PR_ROT_BASE) |-> (physIdx == virtIdx)); // R2
  AST_NO_FILE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (fileSel == 2'd3) |-> (physIdx == virtIdx)); // R9
endmodule

bind rrb_renamer rrb_renamer_chk #(
  .FR_REGS    (FR_REGS),
  .PR_REGS    (PR_REGS),
  .FR_ROT_BASE(FR_ROT_BASE),
  .PR_ROT_BASE(PR_ROT_BASE),
  .IDX_W      (IDX_W),
  .NFILES     (3)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fileSel    (fileSel),
  .virtIdx    (virtIdx),
  .rotateStep (rotateStep),
  .rotateClear(rotateClear),
  .physIdx    (physIdx),
  .baseVec    (baseVec)
);

// File: tb/rrb_renamer_tb.sv
`timescale 1ns/1ps
module rrb_renamer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] fileSel = 2'd0;
  logic [6:0] virtIdx = '0;
  logic [3:0] sorUnits = 4'd4;
  logic       rotateStep = 1'b0;
  logic       rotateClear = 1'b0;
  logic [6:0] physIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mGr = 0, mFr = 0, mPr = 0;

  always #10 clk = ~clk; // 50 MHz

  rrb_renamer u_dut (
    .clk(clk), .rstN(rstN), .fileSel(fileSel), .virtIdx(virtIdx),
    .sorUnits(sorUnits), .rotateStep(rotateStep), .rotateClear(rotateClear),
    .physIdx(physIdx)
  );

  function automatic int grSizeOf(int s);
    return ((s > 12) ? 12 : s) * 8;
  endfunction

  function automatic int expPhys(int sel, int v);
    int st, sz, b;
    if (sel == 3) return v;
    st = (sel == 2) ? 16 : 32;
    sz = (sel == 0) ? grSizeOf(int'(sorUnits)) : (sel == 1) ? 96 : 48;
    b  = (sel == 0) ? mGr : (sel == 1) ? mFr : mPr;
    if (v >= st && v < st + sz) return st + ((v - st) + b) % sz;
    return v;
  endfunction

  task automatic modelStep();
    int sz = grSizeOf(int'(sorUnits));
    mFr = (mFr + 95) % 96;
    mPr = (mPr + 47) % 48;
    if (sz == 0) mGr = 0;
    else if (mGr == 0 || mGr >= sz) mGr = sz - 1;
    else mGr = mGr - 1;
  endtask

  task automatic stepN(int n);
    @(negedge clk);
    rotateStep = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      modelStep();
    end
    rotateStep = 1'b0;
  endtask

  task automatic clearPulse(bit withStep);
    @(negedge clk);
    rotateClear = 1'b1;
    rotateStep  = withStep;
    @(negedge clk);
    rotateClear = 1'b0;
    rotateStep  = 1'b0;
    mGr = 0; mFr = 0; mPr = 0;
  endtask

  task automatic check(string req, int got, int exp, int sel, int v);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s sel=%0d v=%0d: got %0d expected %0d", req, sel, v, got, exp);
    end
  endtask

  // Sweep every file and index; tag picks the requirement for in-region hits.
  task automatic sweep(string tag);
    string req;
    int st, sz;
    for (int sel = 0; sel < 4; sel++) begin
      for (int v = 0; v < 128; v++) begin
        fileSel = 2'(sel);
        virtIdx = 7'(v);
        #1;
        st = (sel == 2) ? 16 : 32;
        sz = (sel == 0) ? grSizeOf(int'(sorUnits)) : (sel == 1) ? 96 : 48;
        if (sel == 3) req = "R9";
        else if (v < st) req = "R2";
        else if (sel == 0 && v >= st + sz) req = "R6";
        else req = tag;
        check(req, int'(physIdx), expPhys(sel, v), sel, v);
      end
    end
  endtask

  initial begin
    sorUnits = 4'd4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1");                       // identity after reset
    stepN(1);
    fileSel = 2'd1; virtIdx = 7'd32; #1;
    check("R4", int'(physIdx), 127, 1, 32);
    fileSel = 2'd2; virtIdx = 7'd16; #1;
    check("R4", int'(physIdx), 63, 2, 16);
    sweep("R4");
    stepN(4);
    sweep("R3");
    stepN(100);                        // every region wraps
    sweep("R4");
    repeat (5) @(negedge clk);         // idle cycles
    sweep("R8");
    clearPulse(1'b1);                  // clear beats step
    sweep("R5");
    stepN(3);
    clearPulse(1'b0);
    sweep("R5");
    @(negedge clk); sorUnits = 4'd15;  // clamp to 12
    stepN(7);
    sweep("R6");
    clearPulse(1'b0);
    @(negedge clk); sorUnits = 4'd0;
    stepN(3);
    sweep("R7");
    @(negedge clk); sorUnits = 4'd2;   // general base must still be zero
    sweep("R7");
    stepN(5);
    sweep("R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule